// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

This block keeps wall-clock time and a full Gregorian calendar inside a chip. A programmable divider counts reference-clock cycles and produces one tick per second; each tick advances seconds, minutes and hours, and on a midnight carry it advances the day of the month, the weekday, the month, the year within the century and the century itself. February length follows the leap-year rule, including the exception for century years.

Software sets any single time field through a field-select write port. Every field can be read directly at the outputs. A sub-second counter is also visible, so time can be read to the resolution of one reference-clock period. An alarm compares year, month, day, hour, minute and second, and each of these has its own enable bit. A second interrupt source can fire on each new second, minute, hour or day, chosen by a mask.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, the time reads century 0, year 0, month 1, day 1, weekday 0, 00:00:00, the sub-second count is 0 and both interrupt outputs are low.
- R2: With `div_ratio` = N (N >= 1), the seconds field advances once every N reference-clock cycles. The first advance comes N cycles after reset or after the last write. With `div_ratio` = 0, time stands still.
- R3: `subsec` counts 0, 1, ..., N-1 within each second. It returns to 0 on the same clock edge that advances the seconds field.
- R4: A write stores `wr_data` into the field chosen by `wr_field`, using these codes: 0 second, 1 minute, 2 hour, 3 day, 4 month, 5 year, 6 century, 7 weekday. The write clears `subsec` to 0, so the next advance comes a full N cycles later. If a tick falls in the same cycle as a write, the tick is dropped.
- R5: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R6: Months 4, 6, 9 and 11 have 30 days. February has 29 days when (century*100 + year) is divisible by 4 and is not a century year not divisible by 400; otherwise it has 28. All other months have 31 days. The day after the last day of a month is day 1 of the next month, and month 12 wraps to month 1 with a carry into the year.
- R7: At each day carry the weekday advances modulo 7, so 6 is followed by 0. The year wraps from 99 to 0 and increments the century. The century wraps from 99 to 0.
- R8: `alarm_irq` is high for exactly one cycle, the first cycle in which the advanced time shows values equal to every enabled alarm field. The enable bits in `alm_en` are: bit 0 second, bit 1 minute, bit 2 hour, bit 3 day, bit 4 month, bit 5 year.
- R9: A field whose enable bit is clear always counts as matching. When `alm_en` is all zero, `alarm_irq` never rises. Writes never raise `alarm_irq`.
- R10: `periodic_irq` is high for one cycle, the cycle in which the advanced time appears, when the advance meets any enabled condition. The bits of `per_en` are: bit 0 every second, bit 1 a new minute, bit 2 a new hour, bit 3 a new day.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_ratio | input | DIV_W | Reference cycles per second |
| wr_en | input | 1 | Field write strobe |
| wr_field | input | 3 | Field select code for writes |
| wr_data | input | 7 | Value to write |
| alm_year | input | 7 | Alarm year within century |
| alm_month | input | 4 | Alarm month |
| alm_day | input | 5 | Alarm day of month |
| alm_hour | input | 5 | Alarm hour |
| alm_min | input | 6 | Alarm minute |
| alm_sec | input | 6 | Alarm second |
| alm_en | input | 6 | Per-field alarm enables |
| per_en | input | 4 | Periodic interrupt selection |
| century | output | 7 | Current century |
| year | output | 7 | Current year within century |
| month | output | 4 | Current month, 1 to 12 |
| day | output | 5 | Current day of month |
| wday | output | 3 | Current weekday, 0 to 6 |
| hour | output | 5 | Current hour |
| minute | output | 6 | Current minute |
| second | output | 6 | Current second |
| subsec | output | DIV_W | Reference cycles elapsed in the current second |
| alarm_irq | output | 1 | Alarm match pulse |
| periodic_irq | output | 1 | Periodic event pulse |

## Verification
Some behaviour holds on every clock cycle, and assertions check it continuously:
- time holds still between ticks and writes;
- a write clears the sub-second count;
- the weekday steps by one at each day carry;
- the second wraps to zero on a minute carry;
- an alarm pulse only appears when every enabled field equals the displayed time.

Other behaviour depends on long sequences of state, and only the bench scenarios can show it:
- the month-length and leap-year rules across February of ordinary, leap, century and 400-year cases;
- the century carry;
- the exact cycle on which a tick lands after a write;
- whether periodic and alarm pulses appear or stay absent.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [6:0] century;
    logic [6:0] year;
    logic [3:0] month;
    logic [4:0] day;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } rtc_time_t;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DAY   = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_YEAR  = 3'd5,
    FLD_CENT  = 3'd6,
    FLD_WDAY  = 3'd7
  } rtc_field_e;

  // Leap test without multiplication: a non-zero year decides on its own;
  // year 0 of a century is leap only when the century is a multiple of 4.
  function automatic logic is_leap(input logic [6:0] cent, input logic [6:0] yr);
    if (yr != 7'd0) return (yr[1:0] == 2'b00);
    return (cent[1:0] == 2'b00);
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2:                     return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
      default:                  return 5'd31;
    endcase
  endfunction

  // Disabled fields always match; an all-zero mask never matches.
  function automatic logic alarm_hit(input rtc_time_t t, input rtc_time_t a,
                                     input logic [5:0] en);
    return (en != 6'd0)
        && (!en[0] || t.sec   == a.sec)
        && (!en[1] || t.min   == a.min)
        && (!en[2] || t.hour  == a.hour)
        && (!en[3] || t.day   == a.day)
        && (!en[4] || t.month == a.month)
        && (!en[5] || t.year  == a.year);
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             wr_en,
  output logic [DIV_W-1:0] subsec,
  output logic             sec_tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] last_cnt;
  logic             ratio_ok;

  assign last_cnt = div_ratio - ONE;
  assign ratio_ok = (div_ratio != '0);
  // A write in the same cycle wins over the tick.
  assign sec_tick = ratio_ok && !wr_en && (subsec >= last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         subsec <= '0;
    else if (wr_en)     subsec <= '0;
    else if (sec_tick)  subsec <= '0;
    else if (ratio_ok)  subsec <= subsec + ONE;
  end

  a_r4_write_clears_subsec: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (subsec == '0));

  a_r3_tick_restarts_count: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> (subsec == '0));

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sec_tick,
  input  logic      wr_en,
  input  logic [2:0] wr_field,
  input  logic [6:0] wr_data,
  output rtc_time_t now,
  output rtc_time_t adv,
  output logic      roll_min,
  output logic      roll_hour,
  output logic      roll_day
);
  logic       roll_mon, roll_year, roll_cent;
  logic [4:0] cur_len;

  assign cur_len   = month_len(now.month, is_leap(now.century, now.year));
  assign roll_min  = (now.sec  >= 6'd59);
  assign roll_hour = roll_min  && (now.min  >= 6'd59);
  assign roll_day  = roll_hour && (now.hour >= 5'd23);
  assign roll_mon  = roll_day  && (now.day  >= cur_len);
  assign roll_year = roll_mon  && (now.month >= 4'd12);
  assign roll_cent = roll_year && (now.year >= 7'd99);

  always_comb begin
    adv     = now;
    adv.sec = roll_min ? 6'd0 : now.sec + 6'd1;
    if (roll_min)  adv.min  = roll_hour ? 6'd0 : now.min + 6'd1;
    if (roll_hour) adv.hour = roll_day  ? 5'd0 : now.hour + 5'd1;
    if (roll_day) begin
      adv.day  = roll_mon ? 5'd1 : now.day + 5'd1;
      adv.wday = (now.wday >= 3'd6) ? 3'd0 : now.wday + 3'd1;
    end
    if (roll_mon)  adv.month = roll_year ? 4'd1 : now.month + 4'd1;
    if (roll_year) adv.year  = roll_cent ? 7'd0 : now.year + 7'd1;
    if (roll_cent) adv.century = (now.century >= 7'd99) ? 7'd0 : now.century + 7'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now       <= '0;
      now.month <= 4'd1;
      now.day   <= 5'd1;
    end else if (wr_en) begin
      case (rtc_field_e'(wr_field))
        FLD_SEC:   now.sec     <= wr_data[5:0];
        FLD_MIN:   now.min     <= wr_data[5:0];
        FLD_HOUR:  now.hour    <= wr_data[4:0];
        FLD_DAY:   now.day     <= wr_data[4:0];
        FLD_MONTH: now.month   <= wr_data[3:0];
        FLD_YEAR:  now.year    <= wr_data;
        FLD_CENT:  now.century <= wr_data;
        default:   now.wday    <= wr_data[2:0];
      endcase
    end else if (sec_tick) begin
      now <= adv;
    end
  end

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !wr_en) |=> (now == $past(now)));

  a_r5_minute_carry_zeroes_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && roll_min) |=> (now.sec == 6'd0));

  a_r7_wday_steps_at_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && roll_day) |=>
      (now.wday == (($past(now.wday) >= 3'd6) ? 3'd0 : $past(now.wday) + 3'd1)));

  a_r6_new_month_starts_day1: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && roll_mon) |=> (now.day == 5'd1));

endmodule

// File: rtl/rtc_events.sv
module rtc_events
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sec_tick,
  input  logic      roll_min,
  input  logic      roll_hour,
  input  logic      roll_day,
  input  rtc_time_t adv,
  input  rtc_time_t alm,
  input  logic [5:0] alm_en,
  input  logic [3:0] per_en,
  output logic      alarm_irq,
  output logic      periodic_irq
);
  logic [3:0] crossing;
  logic       per_hit;
  logic       alm_hit;

  assign crossing = {roll_day, roll_hour, roll_min, 1'b1};
  assign per_hit  = sec_tick && ((crossing & per_en) != 4'd0);
  assign alm_hit  = sec_tick && alarm_hit(adv, alm, alm_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_irq    <= 1'b0;
      periodic_irq <= 1'b0;
    end else begin
      alarm_irq    <= alm_hit;
      periodic_irq <= per_hit;
    end
  end

  a_r10_periodic_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_irq |-> ($past(sec_tick) && ($past(per_en) != 4'd0)));

  a_r9_no_mask_no_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(alm_en) == 6'd0) |-> !alarm_irq);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             wr_en,
  input  logic [2:0]       wr_field,
  input  logic [6:0]       wr_data,
  input  logic [6:0]       alm_year,
  input  logic [3:0]       alm_month,
  input  logic [4:0]       alm_day,
  input  logic [4:0]       alm_hour,
  input  logic [5:0]       alm_min,
  input  logic [5:0]       alm_sec,
  input  logic [5:0]       alm_en,
  input  logic [3:0]       per_en,
  output logic [6:0]       century,
  output logic [6:0]       year,
  output logic [3:0]       month,
  output logic [4:0]       day,
  output logic [2:0]       wday,
  output logic [4:0]       hour,
  output logic [5:0]       minute,
  output logic [5:0]       second,
  output logic [DIV_W-1:0] subsec,
  output logic             alarm_irq,
  output logic             periodic_irq
);
  logic      sec_tick;
  logic      roll_min, roll_hour, roll_day;
  rtc_time_t now, adv, alm;

  always_comb begin
    alm       = '0;
    alm.year  = alm_year;
    alm.month = alm_month;
    alm.day   = alm_day;
    alm.hour  = alm_hour;
    alm.min   = alm_min;
    alm.sec   = alm_sec;
  end

  rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .wr_en(wr_en),
    .subsec(subsec), .sec_tick(sec_tick)
  );

  rtc_timekeeper u_time (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
    .wr_field(wr_field), .wr_data(wr_data), .now(now), .adv(adv),
    .roll_min(roll_min), .roll_hour(roll_hour), .roll_day(roll_day)
  );

  rtc_events u_evt (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .roll_min(roll_min),
    .roll_hour(roll_hour), .roll_day(roll_day), .adv(adv), .alm(alm),
    .alm_en(alm_en), .per_en(per_en), .alarm_irq(alarm_irq),
    .periodic_irq(periodic_irq)
  );

  assign century = now.century;
  assign year    = now.year;
  assign month   = now.month;
  assign day     = now.day;
  assign wday    = now.wday;
  assign hour    = now.hour;
  assign minute  = now.min;
  assign second  = now.sec;

  // R8: a pulse implies the displayed time equals every enabled alarm field
  a_r8_alarm_matches_time: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> ((!alm_en[0] || second == alm_sec) && (!alm_en[1] || minute == alm_min)
                && (!alm_en[2] || hour == alm_hour)  && (!alm_en[3] || day == alm_day)
                && (!alm_en[4] || month == alm_month) && (!alm_en[5] || year == alm_year)));

endmodule

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb;
  localparam int DW  = 16;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] div_ratio = DW'(DIV);
  logic wr_en = 1'b0;
  logic [2:0] wr_field = 3'd0;
  logic [6:0] wr_data = 7'd0;
  logic [6:0] alm_year = 7'd0;
  logic [3:0] alm_month = 4'd0;
  logic [4:0] alm_day = 5'd0, alm_hour = 5'd0;
  logic [5:0] alm_min = 6'd0, alm_sec = 6'd0, alm_en = 6'd0;
  logic [3:0] per_en = 4'd0;
  logic [6:0] century, year;
  logic [3:0] month;
  logic [4:0] day, hour;
  logic [2:0] wday;
  logic [5:0] minute, second;
  logic [DW-1:0] subsec;
  logic alarm_irq, periodic_irq;

  always #2.5 clk = ~clk;

  rtc_calendar #(.DIV_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .wr_en(wr_en),
    .wr_field(wr_field), .wr_data(wr_data), .alm_year(alm_year),
    .alm_month(alm_month), .alm_day(alm_day), .alm_hour(alm_hour),
    .alm_min(alm_min), .alm_sec(alm_sec), .alm_en(alm_en), .per_en(per_en),
    .century(century), .year(year), .month(month), .day(day), .wday(wday),
    .hour(hour), .minute(minute), .second(second), .subsec(subsec),
    .alarm_irq(alarm_irq), .periodic_irq(periodic_irq)
  );

  // Scoreboard item kinds: 0 full time, 1 alarm_irq, 2 periodic_irq, 3 subsec
  typedef struct { int kind; string tag; logic [63:0] exp; } sb_item_t;
  sb_item_t sbq[$];
  event smp_ev;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  function automatic logic [63:0] pk(int c, int y, int mo, int d, int wd, int h, int mi, int s);
    return {21'd0, 7'(c), 7'(y), 4'(mo), 5'(d), 3'(wd), 5'(h), 6'(mi), 6'(s)};
  endfunction

  function automatic logic [63:0] actual(int kind);
    case (kind)
      0: return {21'd0, century, year, month, day, wday, hour, minute, second};
      1: return {63'd0, alarm_irq};
      2: return {63'd0, periodic_irq};
      default: return {48'd0, subsec};
    endcase
  endfunction

  function automatic int ref_days(int c, int y, int mo);
    int full = c * 100 + y;
    bit lp = ((full % 4 == 0) && (full % 100 != 0)) || (full % 400 == 0);
    if (mo == 2) return lp ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic drain();
    while (sbq.size() > 0) begin
      sb_item_t it = sbq.pop_front();
      logic [63:0] a = actual(it.kind);
      n_vec++;
      if (a !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, a, it.exp);
      end
    end
  endtask

  initial forever begin
    @(smp_ev);
    drain();
  end

  task automatic expect_item(int kind, string tag, logic [63:0] exp);
    sb_item_t it;
    it.kind = kind; it.tag = tag; it.exp = exp;
    sbq.push_back(it);
    -> smp_ev;
  endtask

  task automatic wr(int fld, int val);
    wr_en = 1'b1; wr_field = 3'(fld); wr_data = 7'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Field codes: 0 sec 1 min 2 hour 3 day 4 month 5 year 6 century 7 weekday
  task automatic set_time(int c, int y, int mo, int d, int wd, int h, int mi, int s);
    wr(6, c); wr(5, y); wr(4, mo); wr(3, d); wr(7, wd); wr(2, h); wr(1, mi); wr(0, s);
  endtask

  task automatic ticks(int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic finish_run();
    #1 drain();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_item(0, "R1 reset time", pk(0, 0, 1, 1, 0, 0, 0, 0));
    expect_item(3, "R1 reset subsec", 64'd0);
    expect_item(1, "R1 reset alarm", 64'd0);
    expect_item(2, "R1 reset periodic", 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: subsec counts, R2: second advances after DIV cycles
    expect_item(3, "R3 subsec one", 64'd1);
    repeat (2) @(negedge clk);
    expect_item(3, "R3 subsec last", 64'(DIV - 1));
    expect_item(0, "R2 no advance before N", pk(0, 0, 1, 1, 0, 0, 0, 0));
    @(negedge clk);
    expect_item(0, "R2 first second", pk(0, 0, 1, 1, 0, 0, 0, 1));
    expect_item(3, "R3 subsec wraps", 64'd0);

    // R4: write restarts the divider
    repeat (2) @(negedge clk);
    wr(0, 10);
    repeat (DIV - 1) @(negedge clk);
    expect_item(0, "R4 held after write", pk(0, 0, 1, 1, 0, 0, 0, 10));
    @(negedge clk);
    expect_item(0, "R4 full second later", pk(0, 0, 1, 1, 0, 0, 0, 11));
    // R4: a write on the tick cycle wins
    repeat (DIV - 1) @(negedge clk);
    wr(0, 20);
    expect_item(0, "R4 write beats tick", pk(0, 0, 1, 1, 0, 0, 0, 20));
    expect_item(3, "R4 subsec cleared", 64'd0);

    // R2: ratio 0 freezes time
    div_ratio = '0;
    repeat (20) @(negedge clk);
    expect_item(0, "R2 ratio zero holds", pk(0, 0, 1, 1, 0, 0, 0, 20));
    div_ratio = DW'(DIV);

    // R5: minute and hour carries
    set_time(20, 24, 5, 10, 2, 13, 59, 59);
    ticks(1);
    expect_item(0, "R5 hour carry", pk(20, 24, 5, 10, 2, 14, 0, 0));
    set_time(20, 24, 5, 10, 2, 13, 41, 59);
    ticks(1);
    expect_item(0, "R5 minute carry", pk(20, 24, 5, 10, 2, 13, 42, 0));

    // R6: end of every month for several year kinds
    begin
      int cs[5] = '{20, 20, 21, 20, 19};
      int ys[5] = '{23, 24, 0, 0, 0};
      for (int k = 0; k < 5; k++) begin
        for (int m = 1; m <= 12; m++) begin
          int d = ref_days(cs[k], ys[k], m);
          set_time(cs[k], ys[k], m, d, 2, 23, 59, 59);
          ticks(1);
          if (m < 12)
            expect_item(0, "R6 month end", pk(cs[k], ys[k], m + 1, 1, 3, 0, 0, 0));
          else
            expect_item(0, "R6 year end", pk(cs[k], ys[k] + 1, 1, 1, 3, 0, 0, 0));
        end
      end
    end
    // R6: a leap-year Feb 28 goes to Feb 29
    set_time(20, 24, 2, 28, 4, 23, 59, 59);
    ticks(1);
    expect_item(0, "R6 leap Feb 29", pk(20, 24, 2, 29, 5, 0, 0, 0));

    // R7: weekday wrap, year and century carry
    set_time(19, 99, 12, 31, 6, 23, 59, 59);
    ticks(1);
    expect_item(0, "R7 century carry", pk(20, 0, 1, 1, 0, 0, 0, 0));
    set_time(99, 99, 12, 31, 3, 23, 59, 59);
    ticks(1);
    expect_item(0, "R7 century wrap", pk(0, 0, 1, 1, 4, 0, 0, 0));

    // R8: alarm on second and minute
    alm_sec = 6'd5; alm_min = 6'd30; alm_year = 7'd55; alm_en = 6'b000011;
    set_time(20, 24, 3, 10, 3, 12, 30, 3);
    expect_item(1, "R9 no alarm on write", 64'd0);
    ticks(1);
    expect_item(1, "R8 no alarm before match", 64'd0);
    ticks(1);
    expect_item(1, "R8 alarm on match", 64'd1);
    @(negedge clk);
    expect_item(1, "R8 alarm one cycle", 64'd0);
    // R8: enabled year mismatch blocks
    alm_sec = 6'd7; alm_en = 6'b100001;
    set_time(20, 24, 3, 10, 3, 12, 30, 6);
    ticks(1);
    expect_item(1, "R8 year mismatch", 64'd0);
    // R9: disabled year ignored
    alm_en = 6'b000001;
    set_time(20, 24, 3, 10, 3, 12, 30, 6);
    ticks(1);
    expect_item(1, "R9 disabled field matches", 64'd1);
    // R9: empty mask
    alm_en = 6'b000000;
    set_time(20, 24, 3, 10, 3, 12, 30, 6);
    ticks(1);
    expect_item(1, "R9 empty mask silent", 64'd0);
    // R8: all fields through a carry
    alm_year = 7'd24; alm_month = 4'd3; alm_day = 5'd10; alm_hour = 5'd12;
    alm_min = 6'd31; alm_sec = 6'd0; alm_en = 6'b111111;
    set_time(20, 24, 3, 10, 3, 12, 30, 59);
    ticks(1);
    expect_item(1, "R8 all fields", 64'd1);
    alm_en = 6'd0;
    @(negedge clk);

    // R10: periodic interrupts
    per_en = 4'b0010;
    set_time(20, 24, 3, 10, 3, 10, 0, 58);
    ticks(1);
    expect_item(2, "R10 minute no pulse", 64'd0);
    ticks(1);
    expect_item(2, "R10 minute pulse", 64'd1);
    per_en = 4'b0001;
    ticks(1);
    expect_item(2, "R10 second pulse", 64'd1);
    per_en = 4'b0100;
    set_time(20, 24, 3, 10, 3, 5, 59, 59);
    ticks(1);
    expect_item(2, "R10 hour pulse", 64'd1);
    ticks(1);
    expect_item(2, "R10 hour no pulse", 64'd0);
    per_en = 4'b1000;
    set_time(20, 24, 3, 10, 3, 23, 59, 59);
    ticks(1);
    expect_item(2, "R10 day pulse", 64'd1);
    @(negedge clk);
    expect_item(2, "R10 pulse one cycle", 64'd0);
    per_en = 4'd0;

    finish_run();
  end
endmodule